// File: doc/BRIEF.md
# Transmit/Receive Byte Buffer with Watermark Interrupts

This block sits between the serial shift engine of a synchronous serial controller and its register decoder. It holds two byte queues of equal depth: one that the bus side fills and the shifter drains (transmit), and one that the shifter fills and the bus side drains (receive). Both sides see plain push and pop strobes. The queue fill levels are packed into one status word that software can read.

A small interrupt unit watches the fill levels. It latches a flag when the receive queue is nearly full and another when the transmit queue is nearly drained. A third flag records a transfer-done pulse from the shifter. Software clears the flags by writing ones to them. A separate mask selects which latched flags drive the single interrupt line. Writes to the control word can flush either queue. Each flush strobe is visible for one cycle and then drops by itself.

Top module: `bfi_unit`

## Requirements
- R1: Each queue holds up to DEPTH (default 64) bytes and returns them in push order. The head byte is shown on the queue's read-data port while the queue is not empty.
- R2: The fill-level word carries the receive count in bits [6:0] and the transmit count in bits [22:16]. All other bits are zero, and both counts are zero after reset.
- R3: A push to a full queue changes neither its contents nor its count. A pop from an empty queue has no effect, and an empty queue shows 0x00 on its read-data port.
- R4: A push and a pop in the same cycle on a queue that is neither empty nor full transfer one byte each way and leave the count unchanged.
- R5: A control write with bit 8 set flushes the transmit queue, and bit 9 flushes the receive queue. The strobe is readable at the same bit of the control readback in the following cycle and is gone one cycle later unless rewritten. The queue reads empty after that cycle, and pushes or pops made while the strobe is high are dropped.
- R6: Status bit 4 becomes 1 in the cycle after the receive count is at or above three quarters of DEPTH (48).
- R7: Status bit 12 becomes 1 in the cycle after the transmit count is at or below one quarter of DEPTH (16). This includes the empty queue right after reset.
- R8: Status bit 16 becomes 1 in the cycle after a transfer-done pulse.
- R9: Writing the status word clears every flag whose written bit is 1, and a clear wins over a set arriving in the same cycle. A watermark whose level condition still holds is set again one cycle later. Zero bits, and bits other than 4, 12 and 16, have no effect, and those other bits always read 0.
- R10: The enable register keeps only bits 4, 12 and 16 of a write. The interrupt output is 1 exactly when some status bit and the same enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Bus side writes a byte to the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Shifter takes the head byte of the transmit queue |
| tx_rdata | output | 8 | Head byte of the transmit queue, 0 when empty |
| rx_push | input | 1 | Shifter writes a received byte |
| rx_wdata | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Bus side takes the head byte of the receive queue |
| rx_rdata | output | 8 | Head byte of the receive queue, 0 when empty |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word data; bit 8 flushes transmit, bit 9 flushes receive |
| ctl_rdata | output | 32 | Control readback showing the live flush strobes |
| ien_wr | input | 1 | Enable mask write strobe |
| ien_wdata | input | 32 | Enable mask data |
| sts_wr | input | 1 | Status write (write one to clear) strobe |
| sts_wdata | input | 32 | Bits to clear |
| xfer_done | input | 1 | Transfer-complete pulse from the shifter |
| fifo_status | output | 32 | Packed fill counts of both queues |
| irq_status | output | 32 | Latched flags |
| irq_enable | output | 32 | Enable mask |
| irq | output | 1 | Combined interrupt |

## Verification
The queues are first driven with long one-sided runs: the transmit side is filled to full and beyond, and the receive side is filled past its watermark and then drained beyond empty. These runs separate correct boundary handling from off-by-one count limits and show each watermark edge on both sides of its threshold. Next come simultaneous push and pop, flushes that coincide with pushes, and clears issued while a level still holds. These show how same-cycle events are ordered. A long stretch of random pushes, pops, clears, mask writes and done pulses is then compared every clock against a queue-based reference model, which catches mismatches in mask gating and in the readback of the queue head.

// File: rtl/bfi_pkg.sv
package bfi_pkg;
   localparam int WORD_W       = 32;
   localparam int FLAG_RX_HI   = 4;
   localparam int FLAG_TX_LO   = 12;
   localparam int FLAG_DONE    = 16;
   localparam int CTL_TX_FLUSH = 8;
   localparam int CTL_RX_FLUSH = 9;
   localparam int RXCNT_LSB    = 0;
   localparam int TXCNT_LSB    = 16;
   localparam int CNT_FIELD_W  = 7;
   localparam logic [WORD_W-1:0] FLAG_MASK =
      (32'd1 << FLAG_RX_HI) | (32'd1 << FLAG_TX_LO) | (32'd1 << FLAG_DONE);
   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bfi_fifo.sv
module bfi_fifo #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CW-1:0]    count
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("bfi_fifo: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt_q;
   logic             full, empty, push_ok, pop_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   assign rdata = empty ? '0 : mem[rptr];
   assign count = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R1
   AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH) && push && !pop && !flush) |=> $stable(count)); // R3
   AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push) |=> (count == '0 && rdata == '0)); // R3
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0)); // R5
endmodule

// File: rtl/bfi_irq.sv
module bfi_irq
   import bfi_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH) + 1,
   localparam int RX_HI = (DEPTH * 3) / 4,
   localparam int TX_LO = DEPTH / 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] tx_cnt,
   input  logic          xfer_done,
   input  logic          sts_wr,
   input  word_t         sts_wdata,
   input  logic          ien_wr,
   input  word_t         ien_wdata,
   output word_t         sts,
   output word_t         ien,
   output logic          irq
);
   word_t sts_q, ien_q, set_v, clr_v;

   always_comb begin
      set_v = '0;
      set_v[FLAG_RX_HI] = (int'(rx_cnt) >= RX_HI);
      set_v[FLAG_TX_LO] = (int'(tx_cnt) <= TX_LO);
      set_v[FLAG_DONE]  = xfer_done;
      clr_v = sts_wr ? (sts_wdata & FLAG_MASK) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         ien_q <= '0;
      end else begin
         sts_q <= (sts_q | set_v) & ~clr_v & FLAG_MASK;
         if (ien_wr) ien_q <= ien_wdata & FLAG_MASK;
      end
   end

   assign sts = sts_q;
   assign ien = ien_q;
   assign irq = |(sts_q & ien_q);

   AST_RX_MARK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rx_cnt) >= RX_HI && !(sts_wr && sts_wdata[FLAG_RX_HI])) |=> sts[FLAG_RX_HI]); // R6
   AST_TX_MARK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_cnt) <= TX_LO && !(sts_wr && sts_wdata[FLAG_TX_LO])) |=> sts[FLAG_TX_LO]); // R7
   AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !(sts_wr && sts_wdata[FLAG_DONE])) |=> sts[FLAG_DONE]); // R8
   AST_W1C_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && sts_wdata[FLAG_RX_HI]) |=> !sts[FLAG_RX_HI]); // R9
   AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && sts_wdata[FLAG_DONE]) |=> !sts[FLAG_DONE]); // R9
   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_wr && ien_wdata == '0) |=> !irq); // R10
endmodule

// File: rtl/bfi_unit.sv
module bfi_unit
   import bfi_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_push,
   input  logic [WIDTH-1:0] tx_wdata,
   input  logic             tx_pop,
   output logic [WIDTH-1:0] tx_rdata,
   input  logic             rx_push,
   input  logic [WIDTH-1:0] rx_wdata,
   input  logic             rx_pop,
   output logic [WIDTH-1:0] rx_rdata,
   input  logic             ctl_wr,
   input  logic [31:0]      ctl_wdata,
   output logic [31:0]      ctl_rdata,
   input  logic             ien_wr,
   input  logic [31:0]      ien_wdata,
   input  logic             sts_wr,
   input  logic [31:0]      sts_wdata,
   input  logic             xfer_done,
   output logic [31:0]      fifo_status,
   output logic [31:0]      irq_status,
   output logic [31:0]      irq_enable,
   output logic             irq
);
   localparam int NQ   = 2;
   localparam int Q_TX = 0;
   localparam int Q_RX = 1;

   generate
      if (CW > CNT_FIELD_W) begin : g_bad_cnt
         $error("bfi_unit: DEPTH too large for the count fields");
      end
   endgenerate

   logic [NQ-1:0]    flush_q, push_v, pop_v;
   logic [WIDTH-1:0] wdata_v [NQ];
   logic [WIDTH-1:0] rdata_v [NQ];
   logic [CW-1:0]    cnt_v   [NQ];
   logic             unused_ctl;

   assign unused_ctl = ^ctl_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_q <= '0;
      else if (ctl_wr) begin
         flush_q[Q_TX] <= ctl_wdata[CTL_TX_FLUSH];
         flush_q[Q_RX] <= ctl_wdata[CTL_RX_FLUSH];
      end else flush_q <= '0;
   end

   assign push_v[Q_TX]  = tx_push;
   assign pop_v[Q_TX]   = tx_pop;
   assign wdata_v[Q_TX] = tx_wdata;
   assign push_v[Q_RX]  = rx_push;
   assign pop_v[Q_RX]   = rx_pop;
   assign wdata_v[Q_RX] = rx_wdata;

   for (genvar gi = 0; gi < NQ; gi++) begin : g_q
      bfi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) q_i (
         .clk   (clk),
         .rst_n (rst_n),
         .flush (flush_q[gi]),
         .push  (push_v[gi]),
         .wdata (wdata_v[gi]),
         .pop   (pop_v[gi]),
         .rdata (rdata_v[gi]),
         .count (cnt_v[gi])
      );
   end

   assign tx_rdata = rdata_v[Q_TX];
   assign rx_rdata = rdata_v[Q_RX];

   always_comb begin
      fifo_status = '0;
      fifo_status[TXCNT_LSB +: CW] = cnt_v[Q_TX];
      fifo_status[RXCNT_LSB +: CW] = cnt_v[Q_RX];
      ctl_rdata = '0;
      ctl_rdata[CTL_TX_FLUSH] = flush_q[Q_TX];
      ctl_rdata[CTL_RX_FLUSH] = flush_q[Q_RX];
   end

   bfi_irq #(.DEPTH(DEPTH)) irq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_cnt    (cnt_v[Q_RX]),
      .tx_cnt    (cnt_v[Q_TX]),
      .xfer_done (xfer_done),
      .sts_wr    (sts_wr),
      .sts_wdata (sts_wdata),
      .ien_wr    (ien_wr),
      .ien_wdata (ien_wdata),
      .sts       (irq_status),
      .ien       (irq_enable),
      .irq       (irq)
   );

   AST_STROBE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[CTL_TX_FLUSH] && !ctl_wr) |=> !ctl_rdata[CTL_TX_FLUSH]); // R5
   AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[CTL_RX_FLUSH] |=> (fifo_status[RXCNT_LSB +: CW] == '0)); // R5
endmodule

// File: tb/bfi_unit_tb_top.sv
`timescale 1ns/1ps
module bfi_unit_tb_top;
   localparam logic [31:0] MASK = 32'h0001_1010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
   logic [7:0] tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
   logic ctl_wr = 0, ien_wr = 0, sts_wr = 0, xfer_done = 0;
   logic [31:0] ctl_wdata = 0, ien_wdata = 0, sts_wdata = 0;
   logic [31:0] ctl_rdata, fifo_status, irq_status, irq_enable;
   logic irq;

   always #2.5 clk = ~clk;

   bfi_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .ien_wr(ien_wr), .ien_wdata(ien_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
      .xfer_done(xfer_done), .fifo_status(fifo_status), .irq_status(irq_status),
      .irq_enable(irq_enable), .irq(irq)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model
   byte unsigned q_tx[$];
   byte unsigned q_rx[$];
   logic [31:0] m_sts = 0, m_ien = 0;
   logic [1:0]  m_flush = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q_tx.delete(); q_rx.delete();
         m_sts = 0; m_ien = 0; m_flush = 0;
      end else begin
         int ctx, crx;
         logic [31:0] setv, clrv;
         ctx = q_tx.size(); crx = q_rx.size();
         setv = 0;
         setv[4]  = (crx >= 48);
         setv[12] = (ctx <= 16);
         setv[16] = xfer_done;
         clrv = sts_wr ? (sts_wdata & MASK) : 32'h0;
         m_sts = (m_sts | setv) & ~clrv & MASK;
         if (ien_wr) m_ien = ien_wdata & MASK;
         if (m_flush[0]) q_tx.delete();
         else begin
            if (tx_pop && ctx > 0) void'(q_tx.pop_front());
            if (tx_push && ctx < 64) q_tx.push_back(tx_wdata);
         end
         if (m_flush[1]) q_rx.delete();
         else begin
            if (rx_pop && crx > 0) void'(q_rx.pop_front());
            if (rx_push && crx < 64) q_rx.push_back(rx_wdata);
         end
         m_flush = ctl_wr ? {ctl_wdata[9], ctl_wdata[8]} : 2'b00;
      end
   end

   // every-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [31:0] cnts;
         cnts = 0;
         cnts[22:16] = 7'(q_tx.size());
         cnts[6:0]   = 7'(q_rx.size());
         check("R2 fill counts", fifo_status, cnts);
         check("R1 tx head", {24'h0, tx_rdata}, {24'h0, (q_tx.size() > 0) ? q_tx[0] : 8'h00});
         check("R1 rx head", {24'h0, rx_rdata}, {24'h0, (q_rx.size() > 0) ? q_rx[0] : 8'h00});
         check("R5 strobe readback", ctl_rdata, {22'h0, m_flush, 8'h0});
         check("R6 rx mark", {31'h0, irq_status[4]}, {31'h0, m_sts[4]});
         check("R7 tx mark", {31'h0, irq_status[12]}, {31'h0, m_sts[12]});
         check("R8 done", {31'h0, irq_status[16]}, {31'h0, m_sts[16]});
         check("R9 other bits", irq_status & ~MASK, 32'h0);
         check("R10 enable", irq_enable, m_ien);
         check("R10 irq", {31'h0, irq}, {31'h0, |(m_sts & m_ien)});
      end
   end

   task automatic step();
      @(negedge clk);
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
      ctl_wr = 0; ien_wr = 0; sts_wr = 0; xfer_done = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] snap;
      repeat (3) @(negedge clk);
      check("R2 reset counts", fifo_status, 32'h0);
      check("R9 reset status", irq_status, 32'h0);
      rst_n = 1;
      step();
      // enable writes keep only flag bits
      step(); ien_wr = 1; ien_wdata = 32'hFFFF_FFFF;
      step();
      check("R10 enable masked", irq_enable, MASK);
      // fill transmit to full and one beyond
      for (int i = 0; i < 65; i++) begin step(); tx_push = 1; tx_wdata = 8'(i + 1); end
      step();
      check("R3 full push ignored count", fifo_status[22:16], 32'd64);
      check("R3 full push ignored head", {24'h0, tx_rdata}, 32'h01);
      // simultaneous push and pop
      step(); tx_pop = 1;
      step(); snap = fifo_status; tx_push = 1; tx_pop = 1; tx_wdata = 8'hAA;
      step();
      check("R4 count unchanged", fifo_status, snap);
      check("R4 head advanced", {24'h0, tx_rdata}, 32'h03);
      // receive past watermark, then drain beyond empty
      for (int i = 0; i < 50; i++) begin step(); rx_push = 1; rx_wdata = 8'(8'h40 + i); end
      for (int i = 0; i < 53; i++) begin step(); rx_pop = 1; end
      step();
      check("R3 empty reads zero", {24'h0, rx_rdata}, 32'h0);
      // drain transmit below watermark
      for (int i = 0; i < 50; i++) begin step(); tx_pop = 1; end
      step(); sts_wr = 1; sts_wdata = 32'h0000_1000;
      step();
      check("R9 cleared", {31'h0, irq_status[12]}, 32'h0);
      step();
      check("R9 level re-sets", {31'h0, irq_status[12]}, 32'h1);
      step(); sts_wr = 1; sts_wdata = 32'h0;
      // flush with concurrent push
      step(); ctl_wr = 1; ctl_wdata = 32'h0000_0300;
      step(); tx_push = 1; rx_push = 1;
      step();
      check("R5 flushed", fifo_status, 32'h0);
      // done pulse and masking
      step(); xfer_done = 1;
      step(); ien_wr = 1; ien_wdata = 32'h0;
      step();
      check("R10 masked quiet", {31'h0, irq}, 32'h0);
      // random mix
      for (int i = 0; i < 4000; i++) begin
         step();
         tx_push = ($urandom_range(0, 99) < 45); tx_wdata = 8'($urandom);
         tx_pop  = ($urandom_range(0, 99) < 40);
         rx_push = ($urandom_range(0, 99) < 45); rx_wdata = 8'($urandom);
         rx_pop  = ($urandom_range(0, 99) < 40);
         xfer_done = ($urandom_range(0, 99) < 3);
         if ($urandom_range(0, 99) < 5) begin sts_wr = 1; sts_wdata = $urandom; end
         if ($urandom_range(0, 99) < 3) begin ien_wr = 1; ien_wdata = $urandom; end
         if ($urandom_range(0, 299) < 2) begin ctl_wr = 1; ctl_wdata = $urandom; end
      end
      step(); step();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule